// File: doc/BRIEF.md
# Decimal Field Pack/Unpack Converter

This block moves a decimal number between two byte layouts. In the zoned layout each byte carries one digit in its low nibble and a zone in its high nibble. In the packed layout each byte carries two digits. The exception is the rightmost byte, which holds one digit in its high nibble and the sign in its low nibble. A single start pulse selects the direction and the two field lengths. The unit then reads the whole source field one byte per cycle over a simple read port, starting at the rightmost byte. After that it writes the destination field one byte per cycle, also starting at the rightmost byte.

In both directions the rightmost byte has its two nibbles exchanged, so the sign travels with the number and is not rewritten. If the destination is longer than the number needs, it is filled with zero digits. If it is shorter, the leading digits are dropped. The unit also reports whether the source sign nibble encodes a negative value. Byte positions on both ports are offsets counted from the rightmost byte of the field, so offset 0 is the rightmost byte.

Top module: `dpk_unit`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en`, `wr_en` and `sign_negative` are all 0.
- R2: One cycle after an accepted `start`, `rd_en` is held high for exactly `src_len_m1+1` consecutive cycles, with `rd_idx` stepping 0,1,2,… and each offset read once. `rd_data` is sampled in the same cycle it is requested.
- R3: Directly after the last read, `wr_en` is held high for exactly `dst_len_m1+1` consecutive cycles, with `wr_idx` stepping 0,1,2,…. Reads and writes never overlap.
- R4: Pack (`op`=0): the destination byte at offset 0 equals the source byte at offset 0 with its nibbles exchanged.
- R5: Pack: the destination byte at offset j≥1 takes its high nibble from the low nibble of source offset 2j and its low nibble from the low nibble of source offset 2j−1. Source zones above offset 0 have no effect.
- R6: Unpack (`op`=1): the destination byte at offset 0 equals the source byte at offset 0 with its nibbles exchanged.
- R7: Unpack: the destination byte at offset j≥1 has high nibble 1111. Its low nibble is the digit at position j, where digit 2k−1 is the low nibble and digit 2k the high nibble of source offset k.
- R8: Digits at positions beyond the source field read as 0. A longer destination is therefore padded with 0x00 when packing and with 0xF0 when unpacking.
- R9: A destination shorter than the source receives only its own `dst_len_m1+1` bytes. The higher digits are dropped and no error is raised.
- R10: `sign_negative` goes to 1 when the sign nibble is 1011 or 1101. It goes to 0 for any other code, including the positive codes 1010, 1100, 1110 and 1111. The sign nibble is the high nibble of source offset 0 when packing and the low nibble when unpacking. The output is updated when that byte is read and is held until the next operation reads its own.
- R11: `done` is a one-cycle pulse in the cycle after the last write. `busy` is 1 from the cycle after an accepted `start` through the `done` cycle.
- R12: `start` is ignored while `busy` is 1. The operation in progress keeps its direction and lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 1 | 0 = pack (zoned to packed), 1 = unpack |
| src_len_m1 | input | LEN_W | Source length in bytes minus one |
| dst_len_m1 | input | LEN_W | Destination length in bytes minus one |
| rd_en | output | 1 | Source byte request |
| rd_idx | output | LEN_W | Source offset from the rightmost byte |
| rd_data | input | 8 | Source byte, valid in the request cycle |
| wr_en | output | 1 | Destination byte write strobe |
| wr_idx | output | LEN_W | Destination offset from the rightmost byte |
| wr_data | output | 8 | Destination byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sign_negative | output | 1 | Source sign nibble encodes a negative value |

## Verification
The bench aims at the positions where the nibble arithmetic breaks down:
- **Rightmost byte.** A design that dropped the zone there, or forced a fixed sign, would put the wrong byte at offset 0.
- **Odd/even digit split when unpacking.** Swapping these would interleave the digits in the wrong order.
- **Padding and truncation.** An unequal-length run would expose a design that let stale buffer contents show through as padding, or that wrote past the destination length.
- **Sign codes.** Every code from 1010 to 1111, plus a non-sign digit, is run through the classifier.
- **Maximum length and mid-run start.** A full 16-byte field checks the widest indices. A start pulse raised mid-run would corrupt the lengths or direction of a design that did not lock them.

// File: rtl/dpk_pkg.sv
package dpk_pkg;

    typedef enum logic {
        OP_PACK   = 1'b0,
        OP_UNPACK = 1'b1
    } dpk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_STORE = 2'd2,
        ST_DONE  = 2'd3
    } dpk_state_e;

    localparam logic [3:0] ZONE_FILL = 4'hF;

    // Minus codes are 1011 and 1101; every other nibble is taken as plus.
    function automatic logic sign_is_neg(input logic [3:0] s);
        return (s == 4'hB) || (s == 4'hD);
    endfunction

    function automatic logic [7:0] nib_swap(input logic [7:0] b);
        return {b[3:0], b[7:4]};
    endfunction

endpackage

// File: rtl/dpk_seq.sv
module dpk_seq
    import dpk_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_in,
    input  logic [LEN_W-1:0] src_last_in,
    input  logic [LEN_W-1:0] dst_last_in,
    output dpk_state_e       state,
    output logic [LEN_W-1:0] cnt,
    output dpk_op_e          op_q,
    output logic [LEN_W-1:0] src_last,
    output logic [LEN_W-1:0] dst_last,
    output logic             accept
);

    assign accept = start && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            op_q     <= OP_PACK;
            src_last <= '0;
            dst_last <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q     <= dpk_op_e'(op_in);
                        src_last <= src_last_in;
                        dst_last <= dst_last_in;
                        cnt      <= '0;
                        state    <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (cnt == src_last) begin
                        cnt   <= '0;
                        state <= ST_STORE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STORE: begin
                    if (cnt == dst_last) begin
                        cnt   <= '0;
                        state <= ST_DONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R12: an operation in flight keeps its setup.
    p_setup_locked_r12: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) && $past(state != ST_IDLE) && !$past(rst)
            |-> $stable(op_q) && $stable(src_last) && $stable(dst_last));

    // R11: the completion state lasts exactly one cycle.
    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_IDLE));

endmodule

// File: rtl/dpk_src_buf.sv
module dpk_src_buf
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    load_en,
    input  logic [LEN_W-1:0]        load_idx,
    input  logic [7:0]              load_data,
    output logic [MAX_LEN-1:0][7:0] bytes_q
);

    for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                bytes_q[g] <= 8'h00;
            end else if (load_en && (load_idx == LEN_W'(g))) begin
                bytes_q[g] <= load_data;
            end
        end
    end

endmodule

// File: rtl/dpk_dst_gen.sv
module dpk_dst_gen
    import dpk_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 4
) (
    input  logic [MAX_LEN-1:0][7:0] bytes_q,
    input  dpk_op_e                 op,
    input  logic [LEN_W-1:0]        idx,
    output logic [7:0]              out_byte
);

    localparam int KW = LEN_W + 2;

    logic [KW-1:0] jx;
    logic [KW-1:0] k_hi;
    logic [KW-1:0] k_lo;
    logic [7:0]    b_hi;
    logic [7:0]    b_lo;

    always_comb begin
        jx = KW'(idx);
        if (op == OP_PACK) begin
            k_hi = jx << 1;
            k_lo = (jx << 1) - 1'b1;
        end else begin
            k_hi = (jx + 1'b1) >> 1;
            k_lo = k_hi;
        end
        b_hi = (k_hi < KW'(MAX_LEN)) ? bytes_q[k_hi[LEN_W-1:0]] : 8'h00;
        b_lo = (k_lo < KW'(MAX_LEN)) ? bytes_q[k_lo[LEN_W-1:0]] : 8'h00;

        if (idx == '0) begin
            out_byte = nib_swap(bytes_q[0]);
        end else if (op == OP_PACK) begin
            out_byte = {b_hi[3:0], b_lo[3:0]};
        end else if (idx[0]) begin
            out_byte = {ZONE_FILL, b_lo[3:0]};
        end else begin
            out_byte = {ZONE_FILL, b_hi[7:4]};
        end
    end

endmodule

// File: rtl/dpk_unit.sv
module dpk_unit
    import dpk_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op,
    input  logic [LEN_W-1:0] src_len_m1,
    input  logic [LEN_W-1:0] dst_len_m1,
    output logic             rd_en,
    output logic [LEN_W-1:0] rd_idx,
    input  logic [7:0]       rd_data,
    output logic             wr_en,
    output logic [LEN_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             busy,
    output logic             done,
    output logic             sign_negative
);

    dpk_state_e              state;
    logic [LEN_W-1:0]        cnt;
    dpk_op_e                 op_q;
    logic [LEN_W-1:0]        src_last;
    logic [LEN_W-1:0]        dst_last;
    logic                    accept;
    logic [MAX_LEN-1:0][7:0] bytes_q;

    dpk_seq #(.LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .op_in       (op),
        .src_last_in (src_len_m1),
        .dst_last_in (dst_len_m1),
        .state       (state),
        .cnt         (cnt),
        .op_q        (op_q),
        .src_last    (src_last),
        .dst_last    (dst_last),
        .accept      (accept)
    );

    assign rd_en  = (state == ST_LOAD);
    assign rd_idx = cnt;
    assign wr_en  = (state == ST_STORE);
    assign wr_idx = cnt;
    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_DONE);

    dpk_src_buf #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .load_en   (rd_en),
        .load_idx  (rd_idx),
        .load_data (rd_data),
        .bytes_q   (bytes_q)
    );

    dpk_dst_gen #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_gen (
        .bytes_q  (bytes_q),
        .op       (op_q),
        .idx      (cnt),
        .out_byte (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sign_negative <= 1'b0;
        end else if (rd_en && (rd_idx == '0)) begin
            sign_negative <= sign_is_neg(op_q == OP_UNPACK ? rd_data[3:0] : rd_data[7:4]);
        end
    end

    // R3: the read and write ports are never active together.
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

    // R2: successive reads walk the offsets one by one.
    p_rd_step_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en && $past(rd_en) && !$past(rst) |-> rd_idx == $past(rd_idx) + 1'b1);

    // R3: successive writes walk the offsets one by one.
    p_wr_step_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en && $past(wr_en) && !$past(rst) |-> wr_idx == $past(wr_idx) + 1'b1);

    // R11: completion follows the final destination byte.
    p_done_after_last_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(done) && !$past(rst) |-> $past(wr_en) && ($past(wr_idx) == dst_last));

    // R7: unpacked bytes above offset 0 carry the fill zone.
    p_unpack_zone_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en && (op_q == OP_UNPACK) && (wr_idx != '0) |-> wr_data[7:4] == ZONE_FILL);

endmodule

// File: tb/dpk_unit_test.sv
module dpk_unit_test;

    localparam int MAX_LEN = 16;
    localparam int LEN_W   = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             op = 1'b0;
    logic [LEN_W-1:0] src_len_m1 = '0;
    logic [LEN_W-1:0] dst_len_m1 = '0;
    logic             rd_en;
    logic [LEN_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    logic             wr_en;
    logic [LEN_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic             busy;
    logic             done;
    logic             sign_negative;

    always #10 clk = ~clk;

    dpk_unit #(.MAX_LEN(MAX_LEN)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src_len_m1(src_len_m1), .dst_len_m1(dst_len_m1),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .busy(busy), .done(done), .sign_negative(sign_negative)
    );

    logic [7:0] src_mem [MAX_LEN];
    assign rd_data = src_mem[rd_idx];

    int checks = 0;
    int errors = 0;
    logic [11:0] expq [$];
    int  rd_cnt = 0;
    int  wr_cnt = 0;
    int  cur_dlen = 1;
    logic prev_last_wr = 1'b0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: read order, write scoreboard, done placement.
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_en) begin
                chk(rd_idx == LEN_W'(rd_cnt), "R2 read offset", int'(rd_idx), rd_cnt);
                rd_cnt++;
            end
            if (wr_en) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R9 unexpected write", int'(wr_idx), -1);
                end else begin
                    logic [11:0] e;
                    e = expq.pop_front();
                    chk(wr_idx == e[11:8], "R3 write offset", int'(wr_idx), int'(e[11:8]));
                    chk(wr_data == e[7:0], "R4-R8 data R5 R7 R8", int'(wr_data), int'(e[7:0]));
                end
                wr_cnt++;
            end
            if (done)
                chk(prev_last_wr, "R11 done after last write", int'(prev_last_wr), 1);
            prev_last_wr = wr_en && (int'(wr_idx) == cur_dlen - 1);
        end
    end

    task automatic run_op(input logic opv, input int slen, input int dlen,
                          input logic poke, input string tag);
        logic [3:0] dg [40];
        logic [3:0] sg;
        int n;
        for (int i = 0; i < 40; i++) dg[i] = 4'h0;
        if (opv == 1'b0) begin
            sg = src_mem[0][7:4];
            for (int k = 0; k < slen; k++) dg[k] = src_mem[k][3:0];
        end else begin
            sg = src_mem[0][3:0];
            dg[0] = src_mem[0][7:4];
            for (int k = 1; k < slen; k++) begin
                dg[2*k-1] = src_mem[k][3:0];
                dg[2*k]   = src_mem[k][7:4];
            end
        end
        for (int j = 0; j < dlen; j++) begin
            logic [7:0] b;
            if (opv == 1'b0) b = (j == 0) ? {dg[0], sg} : {dg[2*j], dg[2*j-1]};
            else             b = (j == 0) ? {sg, dg[0]} : {4'hF, dg[j]};
            expq.push_back({4'(j), b});
        end
        rd_cnt = 0;
        wr_cnt = 0;
        cur_dlen = dlen;
        @(negedge clk);
        start = 1'b1;
        op = opv;
        src_len_m1 = 4'(slen - 1);
        dst_len_m1 = 4'(dlen - 1);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            start = 1'b1;
            op = ~opv;
            src_len_m1 = 4'd0;
            dst_len_m1 = 4'd0;
            @(negedge clk);
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        #1;
        chk(done, {tag, " R11 done seen"}, int'(done), 1);
        chk(busy, {tag, " R11 busy in done cycle"}, int'(busy), 1);
        chk(rd_cnt == slen, {tag, " R2 read count"}, rd_cnt, slen);
        chk(wr_cnt == dlen, {tag, " R9 R12 write count"}, wr_cnt, dlen);
        chk(expq.size() == 0, {tag, " R3 all written"}, expq.size(), 0);
        n = (sg == 4'hB || sg == 4'hD) ? 1 : 0;
        chk(sign_negative == n[0], {tag, " R10 sign"}, int'(sign_negative), n);
        @(negedge clk);
        #1;
        chk(!done && !busy, {tag, " R11 pulse ends"}, int'({done, busy}), 0);
        expq.delete();
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MAX_LEN; i++) src_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(!busy && !done && !rd_en && !wr_en && !sign_negative, "R1 reset state",
            int'({busy, done, rd_en, wr_en, sign_negative}), 0);
        rst = 1'b0;

        // R4 R5: pack 123 plus, equal digit room
        src_mem[0] = 8'hC3; src_mem[1] = 8'hF2; src_mem[2] = 8'hF1;
        run_op(1'b0, 3, 2, 1'b0, "pack basic R4 R5");

        // R6 R7: unpack back
        src_mem[0] = 8'h3C; src_mem[1] = 8'h12;
        run_op(1'b1, 2, 3, 1'b0, "unpack basic R6 R7");

        // R8: pack with padding, zones vary
        src_mem[0] = 8'hD7; src_mem[1] = 8'h35; src_mem[2] = 8'hA9;
        run_op(1'b0, 3, 5, 1'b0, "pack pad R8");

        // R8: unpack with padding
        src_mem[0] = 8'h4B; src_mem[1] = 8'h86;
        run_op(1'b1, 2, 6, 1'b0, "unpack pad R8");

        // R9: unpack truncated
        src_mem[0] = 8'h9D; src_mem[1] = 8'h87; src_mem[2] = 8'h65; src_mem[3] = 8'h43;
        run_op(1'b1, 4, 2, 1'b0, "unpack trunc R9");

        // R9: pack truncated
        for (int i = 0; i < 6; i++) src_mem[i] = 8'hF0 | 8'(i + 1);
        run_op(1'b0, 6, 1, 1'b0, "pack trunc R9");

        // R10: every sign code both ways, plus a digit code
        for (int s = 9; s < 16; s++) begin
            src_mem[0] = {4'(s), 4'h5}; src_mem[1] = 8'hF4;
            run_op(1'b0, 2, 1, 1'b0, "pack sign R10");
            src_mem[0] = {4'h5, 4'(s)};
            run_op(1'b1, 1, 1, 1'b0, "unpack sign R10");
        end

        // Max length both ways
        for (int i = 0; i < MAX_LEN; i++) src_mem[i] = 8'(8'h11 * (i % 9) + 8'h0A);
        run_op(1'b1, 16, 16, 1'b0, "unpack max R7");
        run_op(1'b0, 16, 16, 1'b0, "pack max R5");

        // R12: start raised while busy
        src_mem[0] = 8'hB8; src_mem[1] = 8'hF7; src_mem[2] = 8'hF6; src_mem[3] = 8'hF5;
        run_op(1'b0, 4, 3, 1'b1, "busy start R12");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule